// File: doc/BRIEF.md
# Root-Port Configuration Request Router

This block sits between a host-side requester and the configuration paths of a root port. Each request carries a target bus, device, function, byte offset, access size (1, 2 or 4 bytes) and, for writes, data. The router decides whether the request is answered from the port's own local register file, sent across the link as a type-0 or type-1 configuration access, or refused on the spot. A refusal happens when the target device cannot exist or the link is down.

The block takes one request at a time through a valid/ready handshake. `req_ready_o` stays low until the single-cycle response pulse has been issued. Reads have their byte or halfword pulled out of the returned word. Writes have their data moved into the correct byte lanes, with a matching 4-bit byte-enable.

Top module: `cfg_req_router`

## Requirements
- R1: A request whose bus equals `root_bus_i` (device 0, legal size) drives `loc_en_o` for exactly one cycle, with `loc_addr_o` = offset bits [11:2]. `loc_rdata_i` is taken one cycle after that pulse. The response appears three cycles after the request is accepted.
- R2: A request to the root bus with a device number other than 0 is refused as not-found. It causes no local or downstream access.
- R3: A request to a bus whose parent (`req_parent_i`) equals the root bus, with a device number other than 0, is refused as not-found.
- R4: While `link_up_i` is low, any request to a bus other than the root bus is refused as not-found. Root-bus requests are still served.
- R5: A refused request, read or write, responds with status 2'b01 and data 0xFFFFFFFF, and leaves local storage unchanged.
- R6: A legal request to a non-root bus holds `dn_req_o` high until `dn_done_i`, with stable fields. `dn_type1_o` is 0 when the parent is the root bus and 1 otherwise. Bus, device, function and word address are carried out unchanged.
- R7: Read data depends on the size. Size 1 returns the byte at lane (offset & 3) in bits [7:0]. Size 2 returns word >> 8*(offset & 3) masked to 16 bits. Size 4 returns the whole word.
- R8: Writes drive a byte-enable and data that depend on the size. Size 4 uses all four lanes. Size 2 places the halfword at lane (offset & 2). Size 1 places the byte at lane (offset & 3). Only the touched lanes are enabled. Reads drive a byte-enable of 0.
- R9: A request that is not refused but has a size other than 1, 2 or 4 responds with status 2'b10 and data 0, and makes no access. Refusal takes priority over this check.
- R10: `req_ready_o` is high only when no request is in flight, including out of reset. `rsp_valid_o` is a one-cycle pulse, after which `req_ready_o` returns high. A successful response has status 2'b00, and write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| root_bus_i | input | 8 | Bus number of the root port |
| link_up_i | input | 1 | Link is up |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Router can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Target bus number |
| req_parent_i | input | 8 | Upstream (primary) bus of the target bus |
| req_dev_i | input | 5 | Target device |
| req_func_i | input | 3 | Target function |
| req_off_i | input | 12 | Byte offset in configuration space |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_status_o | output | 2 | 00 ok, 01 not-found, 10 bad register |
| rsp_rdata_o | output | 32 | Read data |
| loc_en_o | output | 1 | Local register file access strobe |
| loc_we_o | output | 1 | Local write |
| loc_addr_o | output | 10 | Local word address |
| loc_be_o | output | 4 | Local byte-enable |
| loc_wdata_o | output | 32 | Local lane-positioned write data |
| loc_rdata_i | input | 32 | Local read word, one cycle after strobe |
| dn_req_o | output | 1 | Downstream configuration access pending |
| dn_type1_o | output | 1 | 0 = type-0, 1 = type-1 |
| dn_we_o | output | 1 | Downstream write |
| dn_bus_o | output | 8 | Downstream target bus |
| dn_dev_o | output | 5 | Downstream target device |
| dn_func_o | output | 3 | Downstream target function |
| dn_addr_o | output | 10 | Downstream word address |
| dn_be_o | output | 4 | Downstream byte-enable |
| dn_wdata_o | output | 32 | Downstream lane-positioned write data |
| dn_done_i | input | 1 | Downstream access completed |
| dn_rdata_i | input | 32 | Downstream read word, valid with done |

## Verification
The hardest situations to reach are those where two refusal rules and the size check meet. Examples are an illegal size aimed at a nonexistent device, and a device-0 request one level below the root while the link is down. The stimulus sets `root_bus_i` to a nonzero value and picks the parent and child bus numbers by hand. It toggles `link_up_i` between request groups, so each rule and its precedence is hit alone. Downstream completions arrive after one to three cycles, so the hold of `dn_req_o` and its fields is seen over several edges.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  typedef enum logic [1:0] {
    ST_OK        = 2'b00,
    ST_NOT_FOUND = 2'b01,
    ST_BAD_REG   = 2'b10
  } cfg_status_e;

  typedef enum logic [1:0] {
    RT_LOCAL, RT_TYPE0, RT_TYPE1, RT_REJECT
  } cfg_route_e;

  function automatic logic size_legal(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
  endfunction
endpackage

// File: rtl/cfg_route_dec.sv
module cfg_route_dec
  import cfg_router_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5
) (
  input  logic [BUS_W-1:0] root_bus_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [BUS_W-1:0] parent_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic             link_up_i,
  output cfg_route_e       route_o
);
  logic on_root, par_root, dev_nz;
  assign on_root  = (bus_i == root_bus_i);
  assign par_root = (parent_i == root_bus_i);
  assign dev_nz   = (dev_i != '0);

  always_comb begin
    if (!on_root && !link_up_i)    route_o = RT_REJECT;
    else if (on_root && dev_nz)    route_o = RT_REJECT;
    else if (par_root && dev_nz)   route_o = RT_REJECT;
    else if (on_root)              route_o = RT_LOCAL;
    else if (par_root)             route_o = RT_TYPE0;
    else                           route_o = RT_TYPE1;
  end
endmodule

// File: rtl/cfg_lane.sv
module cfg_lane
  import cfg_router_pkg::*;
(
  input  logic [2:0]  size_i,
  input  logic [1:0]  lane_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] rword_i,
  output logic [3:0]  be_o,
  output logic [31:0] wword_o,
  output logic [31:0] rdata_o
);
  logic [31:0] shifted;
  assign shifted = rword_i >> {lane_i, 3'b000};

  always_comb begin
    case (size_i)
      3'd1: begin
        be_o    = 4'b0001 << lane_i;
        wword_o = {24'h0, wdata_i[7:0]} << {lane_i, 3'b000};
        rdata_o = {24'h0, shifted[7:0]};
      end
      3'd2: begin
        be_o    = 4'b0011 << {lane_i[1], 1'b0};
        wword_o = {16'h0, wdata_i[15:0]} << {lane_i[1], 4'b0000};
        rdata_o = {16'h0, shifted[15:0]};
      end
      default: begin
        be_o    = 4'hf;
        wword_o = wdata_i;
        rdata_o = rword_i;
      end
    endcase
  end

  // R8
  always_comb begin
    if (size_legal(size_i)) begin
      be_count_chk: assert ($countones(be_o) == int'(size_i));
    end
  end
endmodule

// File: rtl/cfg_req_router.sv
module cfg_req_router
  import cfg_router_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FUNC_W = 3,
  parameter int OFF_W  = 12,
  localparam int WA_W  = OFF_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  root_bus_i,
  input  logic              link_up_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [BUS_W-1:0]  req_bus_i,
  input  logic [BUS_W-1:0]  req_parent_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [FUNC_W-1:0] req_func_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [2:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              loc_en_o,
  output logic              loc_we_o,
  output logic [WA_W-1:0]   loc_addr_o,
  output logic [3:0]        loc_be_o,
  output logic [31:0]       loc_wdata_o,
  input  logic [31:0]       loc_rdata_i,
  output logic              dn_req_o,
  output logic              dn_type1_o,
  output logic              dn_we_o,
  output logic [BUS_W-1:0]  dn_bus_o,
  output logic [DEV_W-1:0]  dn_dev_o,
  output logic [FUNC_W-1:0] dn_func_o,
  output logic [WA_W-1:0]   dn_addr_o,
  output logic [3:0]        dn_be_o,
  output logic [31:0]       dn_wdata_o,
  input  logic              dn_done_i,
  input  logic [31:0]       dn_rdata_i
);
  typedef enum logic [2:0] {S_IDLE, S_LOC, S_LWAIT, S_DN, S_RSP} state_e;

  state_e            state_q;
  cfg_route_e        route;
  cfg_status_e       status_q;
  logic              we_q, type1_q;
  logic [BUS_W-1:0]  bus_q;
  logic [DEV_W-1:0]  dev_q;
  logic [FUNC_W-1:0] func_q;
  logic [OFF_W-1:0]  off_q;
  logic [2:0]        size_q;
  logic [31:0]       wdata_q, rdata_q;
  logic [3:0]        be;
  logic [31:0]       wword, rword, rdata_x;
  logic              accept;

  cfg_route_dec #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_dec (
    .root_bus_i (root_bus_i),
    .bus_i      (req_bus_i),
    .parent_i   (req_parent_i),
    .dev_i      (req_dev_i),
    .link_up_i  (link_up_i),
    .route_o    (route)
  );

  assign rword = (state_q == S_DN) ? dn_rdata_i : loc_rdata_i;

  cfg_lane u_lane (
    .size_i  (size_q),
    .lane_i  (off_q[1:0]),
    .wdata_i (wdata_q),
    .rword_i (rword),
    .be_o    (be),
    .wword_o (wword),
    .rdata_o (rdata_x)
  );

  assign req_ready_o = (state_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      we_q     <= 1'b0;
      type1_q  <= 1'b0;
      bus_q    <= '0;
      dev_q    <= '0;
      func_q   <= '0;
      off_q    <= '0;
      size_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          we_q    <= req_we_i;
          bus_q   <= req_bus_i;
          dev_q   <= req_dev_i;
          func_q  <= req_func_i;
          off_q   <= req_off_i;
          size_q  <= req_size_i;
          wdata_q <= req_wdata_i;
          type1_q <= (route == RT_TYPE1);
          if (route == RT_REJECT) begin
            status_q <= ST_NOT_FOUND;
            rdata_q  <= '1;
            state_q  <= S_RSP;
          end else if (!size_legal(req_size_i)) begin
            status_q <= ST_BAD_REG;
            rdata_q  <= '0;
            state_q  <= S_RSP;
          end else begin
            status_q <= ST_OK;
            state_q  <= (route == RT_LOCAL) ? S_LOC : S_DN;
          end
        end
        S_LOC: state_q <= S_LWAIT;
        S_LWAIT: begin
          rdata_q <= we_q ? '0 : rdata_x;
          state_q <= S_RSP;
        end
        S_DN: if (dn_done_i) begin
          rdata_q <= we_q ? '0 : rdata_x;
          state_q <= S_RSP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid_o  = (state_q == S_RSP);
  assign rsp_status_o = status_q;
  assign rsp_rdata_o  = rdata_q;

  assign loc_en_o    = (state_q == S_LOC);
  assign loc_we_o    = we_q;
  assign loc_addr_o  = off_q[OFF_W-1:2];
  assign loc_be_o    = we_q ? be : 4'h0;
  assign loc_wdata_o = wword;

  assign dn_req_o   = (state_q == S_DN);
  assign dn_type1_o = type1_q;
  assign dn_we_o    = we_q;
  assign dn_bus_o   = bus_q;
  assign dn_dev_o   = dev_q;
  assign dn_func_o  = func_q;
  assign dn_addr_o  = off_q[OFF_W-1:2];
  assign dn_be_o    = we_q ? be : 4'h0;
  assign dn_wdata_o = wword;

  // R10
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  // R10
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  // R5
  not_found_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == ST_NOT_FOUND) |-> rsp_rdata_o == 32'hffff_ffff);
  // R1
  loc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_en_o |=> !loc_en_o);
  // R6
  path_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(loc_en_o && dn_req_o));
  // R6
  dn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_req_o && !dn_done_i) |=> dn_req_o && $stable(dn_addr_o) && $stable(dn_type1_o)
                                 && $stable(dn_bus_o));
endmodule

// File: tb/sim_cfg_req_router.sv
`timescale 1ns/1ps
module sim_cfg_req_router;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  root_bus = 8'h10;
  logic        link_up = 1'b1;
  logic        req_valid_i = 1'b0, req_ready_o, req_we_i = 1'b0;
  logic [7:0]  req_bus_i = '0, req_parent_i = '0;
  logic [4:0]  req_dev_i = '0;
  logic [2:0]  req_func_i = '0;
  logic [11:0] req_off_i = '0;
  logic [2:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [1:0]  rsp_status_o;
  logic [31:0] rsp_rdata_o;
  logic        loc_en_o, loc_we_o;
  logic [9:0]  loc_addr_o;
  logic [3:0]  loc_be_o;
  logic [31:0] loc_wdata_o;
  logic [31:0] loc_rdata_i = '0;
  logic        dn_req_o, dn_type1_o, dn_we_o;
  logic [7:0]  dn_bus_o;
  logic [4:0]  dn_dev_o;
  logic [2:0]  dn_func_o;
  logic [9:0]  dn_addr_o;
  logic [3:0]  dn_be_o;
  logic [31:0] dn_wdata_o;
  logic        dn_done_i = 1'b0;
  logic [31:0] dn_rdata_i = '0;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] lmem [0:1023];

  always #4 clk = ~clk;

  cfg_req_router u0 (
    .clk_i(clk), .rst_ni(rst_ni), .root_bus_i(root_bus), .link_up_i(link_up),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_we_i(req_we_i),
    .req_bus_i(req_bus_i), .req_parent_i(req_parent_i), .req_dev_i(req_dev_i),
    .req_func_i(req_func_i), .req_off_i(req_off_i), .req_size_i(req_size_i),
    .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o), .rsp_status_o(rsp_status_o),
    .rsp_rdata_o(rsp_rdata_o), .loc_en_o(loc_en_o), .loc_we_o(loc_we_o),
    .loc_addr_o(loc_addr_o), .loc_be_o(loc_be_o), .loc_wdata_o(loc_wdata_o),
    .loc_rdata_i(loc_rdata_i), .dn_req_o(dn_req_o), .dn_type1_o(dn_type1_o),
    .dn_we_o(dn_we_o), .dn_bus_o(dn_bus_o), .dn_dev_o(dn_dev_o), .dn_func_o(dn_func_o),
    .dn_addr_o(dn_addr_o), .dn_be_o(dn_be_o), .dn_wdata_o(dn_wdata_o),
    .dn_done_i(dn_done_i), .dn_rdata_i(dn_rdata_i)
  );

  // local register file responder: word ready one cycle after the strobe
  always @(posedge clk) if (loc_en_o) loc_rdata_i <= lmem[loc_addr_o];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int m_start(input logic [11:0] off, input logic [2:0] size);
    if (size == 3'd4) return 0;
    if (size == 3'd2) return off[1] ? 2 : 0;
    return int'(off[1:0]);
  endfunction

  function automatic logic [3:0] m_be(input logic [11:0] off, input logic [2:0] size);
    logic [3:0] b = '0;
    int st = m_start(off, size);
    for (int i = 0; i < 4; i++) if (i >= st && i < st + int'(size)) b[i] = 1'b1;
    return b;
  endfunction

  function automatic logic [31:0] m_wword(input logic [11:0] off, input logic [2:0] size,
                                          input logic [31:0] wd);
    logic [31:0] w = '0;
    logic [3:0]  b = m_be(off, size);
    int st = m_start(off, size);
    for (int i = 0; i < 4; i++) if (b[i]) w[i*8 +: 8] = wd[(i-st)*8 +: 8];
    return w;
  endfunction

  function automatic logic [31:0] m_ext(input logic [31:0] word, input logic [11:0] off,
                                        input logic [2:0] size);
    logic [31:0] s = word >> (8 * int'(off[1:0]));
    if (size == 3'd1) return s & 32'h0000_00ff;
    if (size == 3'd2) return s & 32'h0000_ffff;
    return word;
  endfunction

  function automatic logic [31:0] dn_pat(input logic [7:0] bus, input logic [4:0] dev);
    return 32'h9e37_0000 ^ {16'h0, bus, 3'b000, dev};
  endfunction

  // kind: 0 local, 1 type0, 2 type1, 3 not-found, 4 bad size
  task automatic do_req(input logic we, input logic [7:0] bus, input logic [7:0] par,
                        input logic [4:0] dev, input logic [2:0] fn, input logic [11:0] off,
                        input logic [2:0] size, input logic [31:0] wd, input int lat,
                        input string tag);
    int kind, rsp_c, wi;
    logic [31:0] src, exp_d, eww;
    logic [1:0]  exp_s;
    logic [3:0]  ebe;
    bit on_root = (bus == root_bus);
    bit pr = (par == root_bus);
    if ((!on_root && !link_up) || ((on_root || pr) && dev != 0)) kind = 3;
    else if (!(size == 1 || size == 2 || size == 4)) kind = 4;
    else if (on_root) kind = 0;
    else if (pr) kind = 1;
    else kind = 2;
    rsp_c = (kind == 0) ? 3 : (kind >= 3) ? 1 : lat + 1;
    ebe = m_be(off, size);
    eww = m_wword(off, size, wd);
    wi  = int'(off[11:2]);
    src = (kind == 0) ? lmem[wi] : dn_pat(bus, dev);
    if (kind == 3)      begin exp_s = 2'b01; exp_d = 32'hffff_ffff; end
    else if (kind == 4) begin exp_s = 2'b10; exp_d = 32'h0; end
    else begin exp_s = 2'b00; exp_d = we ? 32'h0 : m_ext(src, off, size); end

    chk($sformatf("%s R10 ready before request", tag), {31'h0, req_ready_o}, 32'h1);
    req_valid_i = 1'b1; req_we_i = we; req_bus_i = bus; req_parent_i = par;
    req_dev_i = dev; req_func_i = fn; req_off_i = off; req_size_i = size; req_wdata_i = wd;
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int c = 1; c <= rsp_c + 1; c++) begin
      chk($sformatf("%s R10 ready c%0d", tag, c), {31'h0, req_ready_o}, {31'h0, c > rsp_c});
      chk($sformatf("%s R10 rsp_valid c%0d", tag, c), {31'h0, rsp_valid_o}, {31'h0, c == rsp_c});
      chk($sformatf("%s R1 loc_en c%0d", tag, c), {31'h0, loc_en_o},
          {31'h0, kind == 0 && c == 1});
      chk($sformatf("%s R6 dn_req c%0d", tag, c), {31'h0, dn_req_o},
          {31'h0, (kind == 1 || kind == 2) && c <= lat});
      if (kind == 0 && c == 1) begin
        chk($sformatf("%s R1 loc_addr", tag), {22'h0, loc_addr_o}, wi);
        chk($sformatf("%s R1 loc_we", tag), {31'h0, loc_we_o}, {31'h0, we});
        chk($sformatf("%s R8 loc_be", tag), {28'h0, loc_be_o}, {28'h0, we ? ebe : 4'h0});
        if (we) begin
          chk($sformatf("%s R8 loc_wdata", tag), loc_wdata_o, eww);
          for (int i = 0; i < 4; i++) if (ebe[i]) lmem[wi][i*8 +: 8] = eww[i*8 +: 8];
        end
      end
      if ((kind == 1 || kind == 2) && c == 1) begin
        chk($sformatf("%s R6 type1", tag), {31'h0, dn_type1_o}, {31'h0, kind == 2});
        chk($sformatf("%s R6 bus", tag), {24'h0, dn_bus_o}, {24'h0, bus});
        chk($sformatf("%s R6 dev", tag), {27'h0, dn_dev_o}, {27'h0, dev});
        chk($sformatf("%s R6 func", tag), {29'h0, dn_func_o}, {29'h0, fn});
        chk($sformatf("%s R6 addr", tag), {22'h0, dn_addr_o}, wi);
        chk($sformatf("%s R6 we", tag), {31'h0, dn_we_o}, {31'h0, we});
        chk($sformatf("%s R8 dn_be", tag), {28'h0, dn_be_o}, {28'h0, we ? ebe : 4'h0});
        if (we) chk($sformatf("%s R8 dn_wdata", tag), dn_wdata_o, eww);
      end
      if ((kind == 1 || kind == 2) && c == lat) begin
        dn_done_i = 1'b1; dn_rdata_i = src;
      end else begin
        dn_done_i = 1'b0;
      end
      if (c == rsp_c) begin
        chk($sformatf("%s status", tag), {30'h0, rsp_status_o}, {30'h0, exp_s});
        chk($sformatf("%s rdata", tag), rsp_rdata_o, exp_d);
      end
      if (c <= rsp_c) @(negedge clk);
    end
    dn_done_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 1024; k++) lmem[k] = 32'h5a00_0000 + k * 32'h0103_0507;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 reset ready", {31'h0, req_ready_o}, 32'h1);
    chk("R10 reset rsp_valid", {31'h0, rsp_valid_o}, 32'h0);
    chk("R1 reset loc_en", {31'h0, loc_en_o}, 32'h0);
    chk("R6 reset dn_req", {31'h0, dn_req_o}, 32'h0);

    // local path, lane handling
    do_req(1, 8'h10, 8'h00, 0, 0, 12'h010, 3'd4, 32'hdead_beef, 1, "R1 R8 local word write");
    do_req(0, 8'h10, 8'h00, 0, 0, 12'h010, 3'd4, 32'h0, 1, "R1 R7 local word read");
    do_req(1, 8'h10, 8'h00, 0, 1, 12'h013, 3'd1, 32'h7777_77ab, 1, "R8 byte write lane3");
    do_req(0, 8'h10, 8'h00, 0, 0, 12'h013, 3'd1, 32'h0, 1, "R7 byte read lane3");
    do_req(1, 8'h10, 8'h00, 0, 0, 12'h016, 3'd2, 32'hffff_1234, 1, "R8 half write lane2");
    do_req(0, 8'h10, 8'h00, 0, 0, 12'h016, 3'd2, 32'h0, 1, "R7 half read lane2");
    do_req(0, 8'h10, 8'h00, 0, 0, 12'h017, 3'd2, 32'h0, 1, "R7 half read odd lane");
    do_req(0, 8'h10, 8'h00, 0, 0, 12'h011, 3'd1, 32'h0, 1, "R7 byte read lane1");
    do_req(1, 8'h10, 8'h00, 0, 0, 12'h021, 3'd1, 32'h0000_0042, 1, "R8 byte write lane1");
    do_req(0, 8'h10, 8'h00, 0, 0, 12'h020, 3'd4, 32'h0, 1, "R7 word after byte write");

    // refusal rules
    do_req(0, 8'h10, 8'h00, 3, 0, 12'h010, 3'd4, 32'h0, 1, "R2 root dev3 read");
    do_req(1, 8'h10, 8'h00, 1, 0, 12'h010, 3'd4, 32'h1111_2222, 1, "R5 refused root write");
    do_req(0, 8'h10, 8'h00, 0, 0, 12'h010, 3'd4, 32'h0, 1, "R5 storage unchanged");
    do_req(0, 8'h11, 8'h10, 1, 0, 12'h000, 3'd4, 32'h0, 1, "R3 below-root dev1");
    do_req(1, 8'h11, 8'h10, 7, 2, 12'h004, 3'd2, 32'h55, 1, "R3 R5 below-root write dev7");

    // downstream
    do_req(0, 8'h11, 8'h10, 0, 5, 12'h008, 3'd4, 32'h0, 1, "R6 type0 word read");
    do_req(1, 8'h11, 8'h10, 0, 3, 12'h002, 3'd1, 32'h0000_00c3, 3, "R6 R8 type0 byte write");
    do_req(0, 8'h12, 8'h11, 5, 6, 12'h106, 3'd2, 32'h0, 2, "R6 R7 type1 half read");
    do_req(1, 8'h20, 8'h12, 9, 1, 12'hffc, 3'd4, 32'h0bad_cafe, 2, "R6 type1 word write");
    do_req(0, 8'h20, 8'h12, 0, 0, 12'h0ff, 3'd1, 32'h0, 3, "R6 R7 type1 byte read");

    // size checks and precedence
    do_req(0, 8'h10, 8'h00, 0, 0, 12'h010, 3'd3, 32'h0, 1, "R9 local size3");
    do_req(1, 8'h12, 8'h11, 0, 0, 12'h010, 3'd0, 32'h9, 1, "R9 type1 size0 write");
    do_req(0, 8'h10, 8'h00, 2, 0, 12'h010, 3'd3, 32'h0, 1, "R9 R2 refusal beats size");

    // link down
    link_up = 1'b0;
    do_req(0, 8'h12, 8'h11, 0, 0, 12'h010, 3'd4, 32'h0, 1, "R4 type1 read link down");
    do_req(1, 8'h11, 8'h10, 0, 0, 12'h010, 3'd4, 32'h3, 1, "R4 type0 write link down");
    do_req(0, 8'h10, 8'h00, 0, 0, 12'h016, 3'd2, 32'h0, 1, "R4 root read link down");
    do_req(0, 8'h11, 8'h10, 0, 0, 12'h010, 3'd7, 32'h0, 1, "R4 R9 link down beats size");
    link_up = 1'b1;
    do_req(0, 8'h11, 8'h10, 0, 0, 12'h00c, 3'd4, 32'h0, 2, "R4 link restored");

    finish_run();
  end
endmodule